// File: doc/BRIEF.md
# Two-Bus Processor Datapath

This block is the processing unit of a small 8-bit stored-program machine. It holds four general-purpose registers, a program counter, an instruction register, a memory address register, an ALU operand register and a one-bit zero-flag register. Two multiplexed buses and an ALU connect them. An external controller sequences the machine by driving load strobes, bus selects, a program-counter increment and an ALU opcode every cycle. The memory array sits outside the block.

The source bus picks one general-purpose register or the program counter. It feeds the ALU, drives the memory write data, and is one input of the destination bus. The destination bus picks the ALU result, the source bus or the memory read data. Every loadable register takes its new value from the destination bus, so a fetched instruction, a fetched operand and an ALU result all travel the same path. The ALU combines the source bus with the operand register. A separate strobe captures whether the ALU result is zero into the zero-flag register.

All interfaces are plain control and data pins sampled on the rising clock edge. The block has no handshake and no back-pressure: the controller owns the timing, and the memory is expected to answer within the cycle. Reset is synchronous and active high.

Top module: `twobus_datapath`

## Requirements
- R1: While `rst` is high at a rising edge, every register (four GPRs, program counter, instruction, address, operand, zero flag) becomes zero. Afterwards `mem_addr`, `instr` and `zero_flag` read 0, and every GPR and the program counter read 0 through the source bus.
- R2: `mem_wdata` always carries the source bus. `bus1_sel` codes 0 to 3 select R0 to R3, code 4 selects the program counter, and codes 5 to 7 drive zero.
- R3: `bus2_sel` code 0 selects the ALU result, 1 the source bus and 2 `mem_rdata`. Code 3 drives zero. At a rising edge, each GPR whose bit is set in `gpr_load` (bit i for Ri) takes the destination bus. Several bits may be set at once.
- R4: When `ir_load` is high, the instruction register takes the destination bus and appears on `instr` after the edge. Otherwise it holds.
- R5: When `ar_load` is high, the address register takes the destination bus and appears on `mem_addr` after the edge. Otherwise it holds.
- R6: When `y_load` is high, the operand register Y takes the destination bus; otherwise it holds. With A the source bus, the ALU result for each `alu_op` code is: 0 gives A, 1 gives A+Y (mod 256), 2 gives A−Y (mod 256), 3 gives A AND Y, 4 gives NOT A. Every other code gives zero.
- R7: When `z_load` is high, `zero_flag` becomes 1 if that cycle's ALU result is zero and 0 if not. Otherwise it holds.
- R8: The program counter loads the destination bus when `pc_load` is high, even if `pc_inc` is also high. Otherwise it adds one when `pc_inc` is high, wrapping from 0xFF to 0x00. With neither strobe high it holds.
- R9: A GPR whose `gpr_load` bit is clear keeps its value whatever the buses carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| gpr_load | input | 4 | Per-register load strobes, bit i for Ri |
| pc_load | input | 1 | Load program counter from destination bus |
| pc_inc | input | 1 | Increment program counter |
| ir_load | input | 1 | Load instruction register |
| ar_load | input | 1 | Load address register |
| y_load | input | 1 | Load ALU operand register |
| z_load | input | 1 | Capture zero flag from ALU result |
| bus1_sel | input | 3 | Source bus select |
| bus2_sel | input | 2 | Destination bus select |
| alu_op | input | 4 | ALU operation code |
| mem_rdata | input | 8 | Memory read data |
| mem_addr | output | 8 | Address register contents |
| mem_wdata | output | 8 | Source bus, used as memory write data |
| instr | output | 8 | Instruction register contents |
| zero_flag | output | 1 | Registered zero flag |

## Verification
The bench goes after the program counter priority: it raises `pc_load` and `pc_inc` together, where a design that let the increment win would show a value one past the loaded address. It also steps the counter across 0xFF, where a design that saturated would stick at 0xFF. It checks the zero flag on a subtraction of equal values and on an addition that overflows to zero, then on a non-zero result with `z_load` low. A flag that was combinational, or that missed the strobe, would show 0 on that last check. It also checks unused select codes, loads into two registers at once, and registers that must hold while the buses carry other data. Each of these would expose a mux that falls through to a stale input or a load decode that is shared.

// File: rtl/dp_pkg.sv
package dp_pkg;
  // ALU operation codes
  localparam logic [3:0] ALU_PASS = 4'd0;
  localparam logic [3:0] ALU_ADD  = 4'd1;
  localparam logic [3:0] ALU_SUB  = 4'd2;
  localparam logic [3:0] ALU_AND  = 4'd3;
  localparam logic [3:0] ALU_NOT  = 4'd4;

  // destination bus sources
  typedef enum logic [1:0] {
    DST_ALU  = 2'd0,
    DST_SRC  = 2'd1,
    DST_MEM  = 2'd2,
    DST_NONE = 2'd3
  } dst_sel_e;
endpackage

// File: rtl/dp_gpr_bank.sv
module dp_gpr_bank #(
  parameter int DW   = 8,
  parameter int NGPR = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NGPR-1:0]          load,
  input  logic [DW-1:0]            din,
  output logic [NGPR-1:0][DW-1:0]  q
);
  for (genvar g = 0; g < NGPR; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)          q[g] <= '0;
      else if (load[g]) q[g] <= din;
    end
  end
endmodule

// File: rtl/dp_src_mux.sv
module dp_src_mux #(
  parameter int DW   = 8,
  parameter int NGPR = 4,
  parameter int SW   = $clog2(NGPR + 1)
) (
  input  logic [NGPR-1:0][DW-1:0] gpr,
  input  logic [DW-1:0]           pc,
  input  logic [SW-1:0]           sel,
  output logic [DW-1:0]           bus
);
  always_comb begin
    bus = '0;
    for (int i = 0; i < NGPR; i++) begin
      if (sel == SW'(i)) bus = gpr[i];
    end
    if (sel == SW'(NGPR)) bus = pc;
  end
endmodule

// File: rtl/dp_dst_mux.sv
module dp_dst_mux
  import dp_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [1:0]    sel,
  input  logic [DW-1:0] alu,
  input  logic [DW-1:0] src,
  input  logic [DW-1:0] mem,
  output logic [DW-1:0] bus
);
  always_comb begin
    case (dst_sel_e'(sel))
      DST_ALU: bus = alu;
      DST_SRC: bus = src;
      DST_MEM: bus = mem;
      default: bus = '0;
    endcase
  end
endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dp_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [3:0]    op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] res
);
  always_comb begin
    case (op)
      ALU_PASS: res = a;
      ALU_ADD:  res = a + b;
      ALU_SUB:  res = a - b;
      ALU_AND:  res = a & b;
      ALU_NOT:  res = ~a;
      default:  res = '0;
    endcase
  end
endmodule

// File: rtl/twobus_datapath.sv
module twobus_datapath #(
  parameter int DW   = 8,
  parameter int NGPR = 4,
  localparam int SW  = $clog2(NGPR + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NGPR-1:0] gpr_load,
  input  logic            pc_load,
  input  logic            pc_inc,
  input  logic            ir_load,
  input  logic            ar_load,
  input  logic            y_load,
  input  logic            z_load,
  input  logic [SW-1:0]   bus1_sel,
  input  logic [1:0]      bus2_sel,
  input  logic [3:0]      alu_op,
  input  logic [DW-1:0]   mem_rdata,
  output logic [DW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  output logic [DW-1:0]   instr,
  output logic            zero_flag
);
  logic [NGPR-1:0][DW-1:0] gpr_q;
  logic [DW-1:0] pc_q, ir_q, ar_q, y_q;
  logic          z_q;
  logic [DW-1:0] bus1, bus2, alu_res;

  dp_gpr_bank #(.DW(DW), .NGPR(NGPR)) u_gpr (
    .clk(clk), .rst(rst), .load(gpr_load), .din(bus2), .q(gpr_q)
  );

  dp_src_mux #(.DW(DW), .NGPR(NGPR), .SW(SW)) u_src (
    .gpr(gpr_q), .pc(pc_q), .sel(bus1_sel), .bus(bus1)
  );

  dp_alu #(.DW(DW)) u_alu (
    .op(alu_op), .a(bus1), .b(y_q), .res(alu_res)
  );

  dp_dst_mux #(.DW(DW)) u_dst (
    .sel(bus2_sel), .alu(alu_res), .src(bus1), .mem(mem_rdata), .bus(bus2)
  );

  // program counter: load beats increment beats hold
  always_ff @(posedge clk) begin
    if (rst)          pc_q <= '0;
    else if (pc_load) pc_q <= bus2;
    else if (pc_inc)  pc_q <= pc_q + DW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ir_q <= '0;
      ar_q <= '0;
      y_q  <= '0;
      z_q  <= 1'b0;
    end else begin
      if (ir_load) ir_q <= bus2;
      if (ar_load) ar_q <= bus2;
      if (y_load)  y_q  <= bus2;
      if (z_load)  z_q  <= (alu_res == '0);
    end
  end

  assign mem_addr  = ar_q;
  assign mem_wdata = bus1;
  assign instr     = ir_q;
  assign zero_flag = z_q;
endmodule

// File: rtl/dp_checker.sv
module dp_checker #(
  parameter int DW   = 8,
  parameter int NGPR = 4,
  parameter int SW   = $clog2(NGPR + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          pc_load,
  input logic          pc_inc,
  input logic          ir_load,
  input logic          ar_load,
  input logic          y_load,
  input logic          z_load,
  input logic [SW-1:0] bus1_sel,
  input logic [DW-1:0] bus2,
  input logic [DW-1:0] alu_res,
  input logic [DW-1:0] pc_q,
  input logic [DW-1:0] y_q,
  input logic [DW-1:0] instr,
  input logic [DW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          zero_flag
);
  // R1
  rst_clear_chk: assert property (@(posedge clk)
    rst |=> (pc_q == '0 && y_q == '0 && instr == '0 && mem_addr == '0 && !zero_flag));

  // R2
  src_pc_chk: assert property (@(posedge clk) disable iff (rst)
    (bus1_sel == SW'(NGPR)) |-> (mem_wdata == pc_q));

  // R4
  ir_capture_chk: assert property (@(posedge clk) disable iff (rst)
    ir_load |=> (instr == $past(bus2)));

  // R4
  ir_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ir_load |=> $stable(instr));

  // R5
  ar_capture_chk: assert property (@(posedge clk) disable iff (rst)
    ar_load |=> (mem_addr == $past(bus2)));

  // R6
  y_capture_chk: assert property (@(posedge clk) disable iff (rst)
    y_load |=> (y_q == $past(bus2)));

  // R7
  zero_capture_chk: assert property (@(posedge clk) disable iff (rst)
    z_load |=> (zero_flag == ($past(alu_res) == '0)));

  // R7
  zero_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !z_load |=> $stable(zero_flag));

  // R8
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (pc_inc && !pc_load) |=> (pc_q == $past(pc_q) + DW'(1)));

  // R8
  pc_load_chk: assert property (@(posedge clk) disable iff (rst)
    pc_load |=> (pc_q == $past(bus2)));
endmodule

bind twobus_datapath dp_checker #(.DW(DW), .NGPR(NGPR), .SW(SW)) u_chk (
  .clk(clk), .rst(rst), .pc_load(pc_load), .pc_inc(pc_inc),
  .ir_load(ir_load), .ar_load(ar_load), .y_load(y_load), .z_load(z_load),
  .bus1_sel(bus1_sel), .bus2(bus2), .alu_res(alu_res), .pc_q(pc_q),
  .y_q(y_q), .instr(instr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .zero_flag(zero_flag)
);

// File: tb/twobus_datapath_test.sv
module twobus_datapath_test;
  localparam int DW   = 8;
  localparam int NGPR = 4;
  localparam int SW   = $clog2(NGPR + 1);

  localparam int P_ADDR = 0;
  localparam int P_IR   = 1;
  localparam int P_Z    = 2;
  localparam int P_WD   = 3;

  typedef struct {
    string         req;
    int            port;
    logic [DW-1:0] exp;
  } item_t;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NGPR-1:0] gpr_load = '0;
  logic            pc_load = 1'b0, pc_inc = 1'b0, ir_load = 1'b0;
  logic            ar_load = 1'b0, y_load = 1'b0, z_load = 1'b0;
  logic [SW-1:0]   bus1_sel = '0;
  logic [1:0]      bus2_sel = '0;
  logic [3:0]      alu_op = '0;
  logic [DW-1:0]   mem_rdata = '0;
  logic [DW-1:0]   mem_addr, mem_wdata, instr;
  logic            zero_flag;

  int    checks = 0;
  int    errors = 0;
  bit    done   = 1'b0;
  item_t sb_q[$];

  always #2 clk = ~clk;  // 250 MHz

  twobus_datapath #(.DW(DW), .NGPR(NGPR)) uut (
    .clk(clk), .rst(rst), .gpr_load(gpr_load), .pc_load(pc_load),
    .pc_inc(pc_inc), .ir_load(ir_load), .ar_load(ar_load), .y_load(y_load),
    .z_load(z_load), .bus1_sel(bus1_sel), .bus2_sel(bus2_sel),
    .alu_op(alu_op), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .instr(instr), .zero_flag(zero_flag)
  );

  // monitor: after each rising edge, compare every queued expectation
  initial begin
    forever begin
      @(posedge clk);
      #1;
      while (sb_q.size() > 0) begin
        item_t it;
        logic [DW-1:0] act;
        it = sb_q.pop_front();
        case (it.port)
          P_ADDR:  act = mem_addr;
          P_IR:    act = instr;
          P_Z:     act = {{(DW-1){1'b0}}, zero_flag};
          default: act = mem_wdata;
        endcase
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s port %0d actual %h expected %h", it.req, it.port, act, it.exp);
        end
      end
    end
  end

  task automatic begin_cyc();
    @(negedge clk);
    rst = 1'b0; gpr_load = '0; pc_load = 1'b0; pc_inc = 1'b0;
    ir_load = 1'b0; ar_load = 1'b0; y_load = 1'b0; z_load = 1'b0;
    bus1_sel = '0; bus2_sel = 2'd3; alu_op = 4'd0; mem_rdata = 8'h5A;
  endtask

  task automatic expect_v(input string req, input int port, input logic [DW-1:0] v);
    item_t it;
    it.req = req; it.port = port; it.exp = v;
    sb_q.push_back(it);
  endtask

  task automatic wr_gpr(input int i, input logic [DW-1:0] v);
    begin_cyc();
    mem_rdata = v; bus2_sel = 2'd2; gpr_load = NGPR'(1) << i;
  endtask

  task automatic rd_src(input int code, input logic [DW-1:0] v, input string req);
    begin_cyc();
    bus1_sel = SW'(code);
    expect_v(req, P_WD, v);
  endtask

  task automatic load_y(input logic [DW-1:0] v);
    begin_cyc();
    mem_rdata = v; bus2_sel = 2'd2; y_load = 1'b1;
  endtask

  // R0 op Y -> R1, optional zero capture; then read R1
  task automatic alu_run(input logic [3:0] op, input bit zl, input logic [DW-1:0] v,
                         input logic zexp, input string req);
    begin_cyc();
    bus1_sel = '0; alu_op = op; bus2_sel = 2'd0; gpr_load = NGPR'(2); z_load = zl;
    expect_v("R7", P_Z, {{(DW-1){1'b0}}, zexp});
    rd_src(1, v, req);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    // R1 reset state
    begin_cyc();
    bus1_sel = SW'(NGPR);
    expect_v("R1", P_ADDR, 8'h00);
    expect_v("R1", P_IR, 8'h00);
    expect_v("R1", P_Z, 8'h00);
    expect_v("R1", P_WD, 8'h00);
    for (int i = 0; i < NGPR; i++) rd_src(i, 8'h00, "R1");

    // R3 loads from memory, R2 reads through source bus
    wr_gpr(0, 8'h3C); wr_gpr(1, 8'hA5); wr_gpr(2, 8'h0F); wr_gpr(3, 8'hF0);
    rd_src(0, 8'h3C, "R3"); rd_src(1, 8'hA5, "R2");
    rd_src(2, 8'h0F, "R2"); rd_src(3, 8'hF0, "R2");
    rd_src(5, 8'h00, "R2"); rd_src(7, 8'h00, "R2");

    // R3 copy via source bus, then dual load
    begin_cyc(); bus1_sel = SW'(1); bus2_sel = 2'd1; gpr_load = 4'b0100;
    rd_src(2, 8'hA5, "R3");
    begin_cyc(); mem_rdata = 8'h77; bus2_sel = 2'd2; gpr_load = 4'b1001;
    rd_src(0, 8'h77, "R3"); rd_src(3, 8'h77, "R3");
    rd_src(1, 8'hA5, "R9");
    // R3 code 3 on destination bus loads zero
    begin_cyc(); bus2_sel = 2'd3; gpr_load = 4'b0100;
    rd_src(2, 8'h00, "R3");
    // R9 hold with busy buses
    begin_cyc(); mem_rdata = 8'h11; bus2_sel = 2'd2;
    rd_src(0, 8'h77, "R9"); rd_src(3, 8'h77, "R9");

    // R4 instruction register
    begin_cyc(); mem_rdata = 8'h9B; bus2_sel = 2'd2; ir_load = 1'b1;
    expect_v("R4", P_IR, 8'h9B);
    begin_cyc(); mem_rdata = 8'h44; bus2_sel = 2'd2;
    expect_v("R4", P_IR, 8'h9B);

    // R5 address register
    begin_cyc(); bus1_sel = SW'(1); bus2_sel = 2'd1; ar_load = 1'b1;
    expect_v("R5", P_ADDR, 8'hA5);
    begin_cyc(); mem_rdata = 8'h12; bus2_sel = 2'd2;
    expect_v("R5", P_ADDR, 8'hA5);
    begin_cyc(); mem_rdata = 8'h12; bus2_sel = 2'd2; ar_load = 1'b1;
    expect_v("R5", P_ADDR, 8'h12);

    // R6 ALU ops with R0=77, Y=10
    load_y(8'h10);
    alu_run(4'd1, 1'b1, 8'h87, 1'b0, "R6");
    alu_run(4'd2, 1'b1, 8'h67, 1'b0, "R6");
    alu_run(4'd3, 1'b1, 8'h10, 1'b0, "R6");
    alu_run(4'd4, 1'b1, 8'h88, 1'b0, "R6");
    alu_run(4'd0, 1'b1, 8'h77, 1'b0, "R6");
    alu_run(4'd9, 1'b1, 8'h00, 1'b1, "R6");
    // R6 Y holds while destination bus changes
    begin_cyc(); mem_rdata = 8'hFF; bus2_sel = 2'd2;
    alu_run(4'd1, 1'b1, 8'h87, 1'b0, "R6");

    // R7 zero flag cases
    load_y(8'h77);
    alu_run(4'd2, 1'b1, 8'h00, 1'b1, "R7");
    alu_run(4'd1, 1'b0, 8'hEE, 1'b1, "R7");
    load_y(8'h89);
    alu_run(4'd1, 1'b1, 8'h00, 1'b1, "R7");
    load_y(8'h01);
    alu_run(4'd1, 1'b1, 8'h78, 1'b0, "R7");

    // R8 program counter
    begin_cyc(); pc_inc = 1'b1;
    begin_cyc(); pc_inc = 1'b1;
    rd_src(NGPR, 8'h02, "R8");
    begin_cyc(); mem_rdata = 8'hFE; bus2_sel = 2'd2; pc_load = 1'b1; pc_inc = 1'b1;
    rd_src(NGPR, 8'hFE, "R8");
    begin_cyc(); pc_inc = 1'b1;
    rd_src(NGPR, 8'hFF, "R8");
    begin_cyc(); pc_inc = 1'b1;
    rd_src(NGPR, 8'h00, "R8");
    rd_src(NGPR, 8'h00, "R8");

    // R1 reset mid-run
    begin_cyc(); rst = 1'b1;
    expect_v("R1", P_ADDR, 8'h00);
    expect_v("R1", P_IR, 8'h00);
    rd_src(0, 8'h00, "R1");
    rd_src(3, 8'h00, "R1");

    begin_cyc();
    @(posedge clk); #2;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule